// File: doc/BRIEF.md
# Microprogram Sequencer

This block produces the micro-program counter of a microcoded processor. Each cycle, while it runs, it takes the next-address field of the microword that the current micro-address selects. It also takes three control bits from that microword: skip-on-true, skip-on-false and dispatch. From these it picks the following micro-address. A conditional control chooses between the stored next address and the sequential address (current plus one), using the ALU zero flag. Dispatch looks up the instruction opcode in an internal table to find the entry point of that instruction's microcode.

The dispatch table is loaded through a simple write port. A table entry of zero marks an undefined opcode. Reaching micro-address zero ends execution. A start pulse loads an entry micro-address and sets the block running. A step counter reports how many micro-steps have run since the last start.

Top module: `micro_sequencer`

## Requirements
- R1: After reset, `mpc` is 0, `running` is 0, `undef_err` is 0, `steps` is 0, and every dispatch-table entry is 0.
- R2: A `start` pulse loads `entry_addr` into `mpc` at the next edge and clears `undef_err` and `steps`. `running` becomes 1 only if `entry_addr` is nonzero. While `start` is high, all microword controls are ignored.
- R3: When running with no control bit set, the next `mpc` equals `next_field`.
- R4: With `ctl_if_true` set, the next `mpc` is `next_field` when `zero` is 0, and `mpc`+1 when `zero` is 1.
- R5: With `ctl_if_false` set, the next `mpc` is `next_field` when `zero` is 1, and `mpc`+1 when `zero` is 0.
- R6: With `ctl_decode` set, the next `mpc` is the table entry indexed by `opcode`, whatever the other controls are. If `ctl_if_true` and `ctl_if_false` are both set, `ctl_if_true` rules.
- R7: `tbl_we` writes `tbl_data` into entry `tbl_idx` at the clock edge. A dispatch to the same index in the same cycle uses the entry's old value.
- R8: A dispatch that reads an entry of 0 sets `mpc` to 0, clears `running` and sets `undef_err`. `undef_err` stays set until the next `start`.
- R9: When the chosen next address is 0, `running` clears. While `running` is 0 and `start` is low, `mpc` and `steps` hold, and all controls have no effect.
- R10: `steps` rises by one for every micro-step taken while running, including the step that halts.
- R11: The sequential address `mpc`+1 wraps modulo 2^UA_W, so a skip taken at the top address leads to 0 and halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at `entry_addr` |
| entry_addr | input | UA_W | Entry micro-address for `start` |
| next_field | input | UA_W | Next-address field of the current microword |
| ctl_if_true | input | 1 | Skip to `mpc`+1 when zero flag set |
| ctl_if_false | input | 1 | Skip to `mpc`+1 when zero flag clear |
| ctl_decode | input | 1 | Dispatch through the opcode table |
| zero | input | 1 | ALU zero flag |
| opcode | input | OP_W | Instruction opcode byte |
| tbl_we | input | 1 | Dispatch-table write enable |
| tbl_idx | input | OP_W | Dispatch-table write index |
| tbl_data | input | UA_W | Dispatch-table write data |
| mpc | output | UA_W | Current micro-address |
| running | output | 1 | Sequencer is stepping |
| undef_err | output | 1 | Undefined opcode was dispatched |
| steps | output | CNT_W | Micro-steps since last start |

## Verification
Two functions can coincide in one cycle: a table write and a dispatch that reads the same entry. The bench provokes this by writing a new entry point for opcode 0x33, which was never loaded, in the same cycle as a dispatch on 0x33. The dispatch must see the old entry of zero and report an undefined opcode. A later restart and dispatch must then reach the new entry. Control bits that conflict within one microword are also checked, both dispatch with a skip and both skip controls together, using next-field values that would expose the wrong priority.

// File: rtl/micro_sequencer.sv
module micro_sequencer #(
  parameter int UA_W  = 8,
  parameter int OP_W  = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [UA_W-1:0]  entry_addr,
  input  logic [UA_W-1:0]  next_field,
  input  logic             ctl_if_true,
  input  logic             ctl_if_false,
  input  logic             ctl_decode,
  input  logic             zero,
  input  logic [OP_W-1:0]  opcode,
  input  logic             tbl_we,
  input  logic [OP_W-1:0]  tbl_idx,
  input  logic [UA_W-1:0]  tbl_data,
  output logic [UA_W-1:0]  mpc,
  output logic             running,
  output logic             undef_err,
  output logic [CNT_W-1:0] steps
);
  localparam int DEPTH = 1 << OP_W;

  logic [UA_W-1:0] dtab [DEPTH];
  logic [UA_W-1:0] seq_addr, disp_addr, next_addr;
  logic            step_en, bad_op;

  assign seq_addr  = mpc + 1'b1;
  assign disp_addr = dtab[opcode];
  assign step_en   = running && !start;
  assign bad_op    = step_en && ctl_decode && (disp_addr == '0);

  always_comb begin
    if (ctl_decode)        next_addr = disp_addr;
    else if (ctl_if_true)  next_addr = zero ? seq_addr : next_field;
    else if (ctl_if_false) next_addr = zero ? next_field : seq_addr;
    else                   next_addr = next_field;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dtab[i] <= '0;
    end else if (tbl_we) begin
      dtab[tbl_idx] <= tbl_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mpc       <= '0;
      running   <= 1'b0;
      undef_err <= 1'b0;
      steps     <= '0;
    end else if (start) begin
      mpc       <= entry_addr;
      running   <= (entry_addr != '0);
      undef_err <= 1'b0;
      steps     <= '0;
    end else if (running) begin
      mpc   <= next_addr;
      steps <= steps + 1'b1;
      if (next_addr == '0) running <= 1'b0;
      if (bad_op) undef_err <= 1'b1;
    end
  end

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mpc == $past(entry_addr)) && (running == ($past(entry_addr) != '0)));

  assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    undef_err |-> !running);

  assert_run_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (mpc != '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(mpc) && $stable(steps)));

  assert_step_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=> (steps == $past(steps) + 1'b1));
endmodule

// File: tb/micro_sequencer_test.sv
module micro_sequencer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [7:0]  entry_addr = 0, next_field = 0, opcode = 0, tbl_idx = 0, tbl_data = 0;
  logic        ctl_if_true = 0, ctl_if_false = 0, ctl_decode = 0, zero = 0, tbl_we = 0;
  logic [7:0]  mpc;
  logic        running, undef_err;
  logic [31:0] steps;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  micro_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .entry_addr(entry_addr),
    .next_field(next_field), .ctl_if_true(ctl_if_true), .ctl_if_false(ctl_if_false),
    .ctl_decode(ctl_decode), .zero(zero), .opcode(opcode), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_data(tbl_data), .mpc(mpc), .running(running),
    .undef_err(undef_err), .steps(steps)
  );

  // vector: {decode, if_true, if_false, zero, next_field, opcode, expected mpc}
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {3'b000, 1'b0, 8'h21, 8'h00, 8'h21},   // R3
    {3'b010, 1'b0, 8'h30, 8'h00, 8'h30},   // R4 zero clear
    {3'b010, 1'b1, 8'h50, 8'h00, 8'h31},   // R4 zero set
    {3'b001, 1'b1, 8'h60, 8'h00, 8'h60},   // R5 zero set
    {3'b001, 1'b0, 8'h70, 8'h00, 8'h61},   // R5 zero clear
    {3'b100, 1'b0, 8'h00, 8'h10, 8'h40},   // R6 dispatch
    {3'b110, 1'b1, 8'h99, 8'h05, 8'h11},   // R6 dispatch over skip
    {3'b011, 1'b0, 8'h22, 8'h00, 8'h22},   // R6 true over false
    {3'b011, 1'b1, 8'h44, 8'h00, 8'h23},   // R6 true over false
    {3'b000, 1'b0, 8'h7e, 8'h00, 8'h7e}    // R3
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clr_ctl();
    {ctl_decode, ctl_if_true, ctl_if_false, zero, opcode, next_field} = '0;
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] d);
    tbl_we = 1; tbl_idx = idx; tbl_data = d; tick(); tbl_we = 0;
  endtask

  task automatic go(logic [7:0] e);
    start = 1; entry_addr = e; tick(); start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) tick();
    chk("R1 mpc", mpc, 0); chk("R1 running", running, 0);
    chk("R1 err", undef_err, 0); chk("R1 steps", steps, 0);
    rst_n = 1;
    // R1: empty table means any dispatch is undefined
    go(8'h08); chk("R2 running", running, 1); chk("R2 mpc", mpc, 8'h08);
    ctl_decode = 1; opcode = 8'h77; tick(); clr_ctl();
    chk("R1 table empty err", undef_err, 1);

    wr(8'h10, 8'h40); wr(8'h05, 8'h11);
    go(8'h20); chk("R2 err cleared", undef_err, 0); chk("R2 steps cleared", steps, 0);
    for (int i = 0; i < NV; i++) begin
      {ctl_decode, ctl_if_true, ctl_if_false, zero, next_field, opcode} = VEC[i][27:8];
      tick();
      chk($sformatf("vector %0d R3-6", i), mpc, VEC[i][7:0]);
    end
    clr_ctl();
    chk("R10 steps", steps, NV);

    next_field = 8'h00; tick();
    chk("R9 halt mpc", mpc, 0); chk("R9 halt running", running, 0);
    chk("R10 halt step counted", steps, NV + 1);
    ctl_decode = 1; opcode = 8'h10; next_field = 8'h55; repeat (3) tick(); clr_ctl();
    chk("R9 idle mpc", mpc, 0); chk("R9 idle steps", steps, NV + 1);

    go(8'h05); ctl_decode = 1; opcode = 8'h33; tick(); clr_ctl();
    chk("R8 mpc", mpc, 0); chk("R8 running", running, 0); chk("R8 err", undef_err, 1);
    repeat (2) tick();
    chk("R8 err held", undef_err, 1);

    go(8'h20);
    tbl_we = 1; tbl_idx = 8'h33; tbl_data = 8'h66; ctl_decode = 1; opcode = 8'h33;
    tick(); tbl_we = 0; clr_ctl();
    chk("R7 old entry used", undef_err, 1);
    go(8'h20); ctl_decode = 1; opcode = 8'h33; tick(); clr_ctl();
    chk("R7 new entry", mpc, 8'h66); chk("R7 running", running, 1);

    go(8'hff); ctl_if_true = 1; zero = 1; next_field = 8'h12; tick(); clr_ctl();
    chk("R11 wrap mpc", mpc, 0); chk("R11 wrap halts", running, 0);

    go(8'h00);
    chk("R2 zero entry running", running, 0); chk("R2 zero entry mpc", mpc, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule